// File: doc/BRIEF.md
# SPI Master with Per-Select Clock Modes

This block is a serial peripheral interface master that moves one 8-bit character per transfer. The character goes out on MOSI and comes in from MISO, most significant bit first. Four active-low select lines share the SCK/MOSI/MISO wires. Each select keeps its own stored clock polarity and phase. Slaves that are fixed in different modes can therefore share the bus without software changing a global setting between transfers.

A small write-only register port holds one mode entry per select and a shared clock divider. A transfer starts with a one-cycle `start_i` while `ready_o` is high. At that point the master takes a copy of the addressed select's mode and of the divider. It first moves SCK to that select's idle level, then asserts the select, runs sixteen SCK edges and releases the select. Finally it presents the received byte with a one-cycle `done_o`.

The phase bit works the opposite way to the common CPHA convention. When `nph`=1, data is captured on the leading SCK edge. When `nph`=0, data changes on the leading edge and is captured on the trailing edge.

Top module: `spi_mcs_master`

## Requirements
- R1: After reset, every select is high, SCK is low, `ready_o` is 1, `done_o` is 0 and `rx_o` is 0.
- R2: A write with address i (0..3) stores the mode of select i, with bit 0 as polarity and bit 1 as `nph`. Address 4 stores the 8-bit divider. Writes to addresses 5..7 have no effect. After reset, every mode entry and the divider are 0.
- R3: SCK idles at the polarity of the select that is addressed. SCK already sits at that level in the cycle the select falls, and it is back at that level when `done_o` rises.
- R4: At most one select is low at any time. The select chosen at start stays low and unchanged for the whole transfer, and all selects are high whenever `ready_o` is high.
- R5: MOSI carries `tx_i` MSB first, and the slave reads it on the capture edges. With `nph`=1, bit 7 is already on MOSI when the select falls. Each transfer has exactly 16 SCK edges.
- R6: MISO is captured MSB first: on leading edges when `nph`=1 and on trailing edges when `nph`=0. The byte appears on `rx_o` in the cycle `done_o` is high, and `rx_o` changes at no other time.
- R7: While a select is low, each SCK half period, and the time from the select falling to the first edge, lasts divider+1 clock cycles.
- R8: `done_o` is a single-cycle pulse, with exactly one per accepted start, and `ready_o` is high while it is raised. A start is accepted only while `ready_o` is high. A start while busy is ignored.
- R9: The mode and divider in use are those stored when the start was accepted. Transfers that follow one another directly may use different selects with different modes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cfg_we_i | input | 1 | Configuration write strobe |
| cfg_addr_i | input | 3 | Configuration address (0..3 select modes, 4 divider) |
| cfg_wdata_i | input | 8 | Configuration write data |
| start_i | input | 1 | Start request, taken while ready_o is high |
| sel_i | input | 2 | Select used by the requested transfer |
| tx_i | input | 8 | Byte to send |
| ready_o | output | 1 | Idle and able to accept a start |
| done_o | output | 1 | One-cycle end-of-transfer pulse |
| rx_o | output | 8 | Last received byte |
| sck_o | output | 1 | Serial clock |
| mosi_o | output | 1 | Serial data out |
| miso_i | input | 1 | Serial data in |
| cs_no | output | 4 | Select lines, active low |

## Verification
The assertions take for granted that `miso_i` is only meaningful between the select falling and the release, and that the register port is not written while a transfer runs. Without that second assumption, checking the copy of the mode taken at start would lose its meaning. The bench drives configuration writes only while `ready_o` is high. Its slave model drives MISO only on its own shift edges while its select is low. It compares received bits only on the eight capture edges, and it issues a start during a busy transfer only to show that the start is ignored.

// File: rtl/spi_mcs_pkg.sv
package spi_mcs_pkg;
  typedef struct packed {
    logic nph;
    logic pol;
  } sel_mode_t;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_ARM,
    ST_RUN,
    ST_TAIL
  } xfer_state_e;
endpackage

// File: rtl/spi_mcs_cfg.sv
module spi_mcs_cfg
  import spi_mcs_pkg::*;
#(
  parameter int NUM_SEL = 4,
  parameter int DIV_W   = 8,
  parameter int ADDR_W  = 3
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DIV_W-1:0]  wdata_i,
  output sel_mode_t         mode_o [NUM_SEL],
  output logic [DIV_W-1:0]  div_o
);
  localparam logic [ADDR_W-1:0] DIV_ADDR = ADDR_W'(NUM_SEL);

  for (genvar g = 0; g < NUM_SEL; g++) begin : g_entry
    sel_mode_t mode_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                                 mode_q <= '0;
      else if (we_i && addr_i == ADDR_W'(g))       mode_q <= sel_mode_t'(wdata_i[1:0]);
    end
    assign mode_o[g] = mode_q;
  end

  logic [DIV_W-1:0] div_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                          div_q <= '0;
    else if (we_i && addr_i == DIV_ADDR)  div_q <= wdata_i;
  end
  assign div_o = div_q;
endmodule

// File: rtl/spi_mcs_tick.sv
module spi_mcs_tick #(
  parameter int DIV_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             run_i,
  input  logic [DIV_W-1:0] div_i,
  output logic             tick_o
);
  logic [DIV_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)            cnt_q <= '0;
    else if (!run_i)        cnt_q <= div_i;
    else if (cnt_q == '0)   cnt_q <= div_i;
    else                    cnt_q <= cnt_q - 1'b1;
  end

  assign tick_o = run_i && (cnt_q == '0);

  assert_tick_bound_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    run_i && !tick_o |=> cnt_q == $past(cnt_q) - 1'b1 || !run_i);
endmodule

// File: rtl/spi_mcs_shift.sv
module spi_mcs_shift #(
  parameter int DATA_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              load_i,
  input  logic [DATA_W-1:0] tx_i,
  input  logic              edge_i,
  input  logic              nph_i,
  input  logic              miso_i,
  output logic              mosi_o,
  output logic [DATA_W-1:0] rx_o,
  output logic              last_o
);
  localparam int EDGE_W = $clog2(2 * DATA_W);
  localparam logic [EDGE_W-1:0] LAST = EDGE_W'(2 * DATA_W - 1);

  logic [DATA_W-1:0] tx_sh, rx_sh;
  logic [EDGE_W-1:0] edge_q;
  logic leading, capt_now, shift_now;

  // even edge index = leading edge
  assign leading   = ~edge_q[0];
  assign capt_now  = nph_i ? leading : ~leading;
  assign shift_now = nph_i ? (~leading && edge_q != LAST) : (leading && edge_q != '0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      tx_sh  <= '0;
      rx_sh  <= '0;
      edge_q <= '0;
    end else if (load_i) begin
      tx_sh  <= tx_i;
      rx_sh  <= '0;
      edge_q <= '0;
    end else if (edge_i) begin
      edge_q <= edge_q + 1'b1;
      if (shift_now) tx_sh <= {tx_sh[DATA_W-2:0], 1'b0};
      if (capt_now)  rx_sh <= {rx_sh[DATA_W-2:0], miso_i};
    end
  end

  assign mosi_o = tx_sh[DATA_W-1];
  assign rx_o   = rx_sh;
  assign last_o = edge_i && (edge_q == LAST);

  assert_mosi_hold_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !load_i && !edge_i |=> $stable(mosi_o));
  assert_capture_kind_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    edge_i && !capt_now && !load_i |=> $stable(rx_sh));
endmodule

// File: rtl/spi_mcs_master.sv
module spi_mcs_master
  import spi_mcs_pkg::*;
#(
  parameter int NUM_SEL = 4,
  parameter int DATA_W  = 8,
  parameter int DIV_W   = 8,
  localparam int SEL_W  = $clog2(NUM_SEL),
  localparam int ADDR_W = $clog2(NUM_SEL + 1)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cfg_we_i,
  input  logic [ADDR_W-1:0] cfg_addr_i,
  input  logic [DIV_W-1:0]  cfg_wdata_i,
  input  logic              start_i,
  input  logic [SEL_W-1:0]  sel_i,
  input  logic [DATA_W-1:0] tx_i,
  output logic              ready_o,
  output logic              done_o,
  output logic [DATA_W-1:0] rx_o,
  output logic              sck_o,
  output logic              mosi_o,
  input  logic              miso_i,
  output logic [NUM_SEL-1:0] cs_no
);
  sel_mode_t        cfg_mode [NUM_SEL];
  logic [DIV_W-1:0] cfg_div;

  spi_mcs_cfg #(.NUM_SEL(NUM_SEL), .DIV_W(DIV_W), .ADDR_W(ADDR_W)) u_cfg (
    .clk_i, .rst_ni,
    .we_i(cfg_we_i), .addr_i(cfg_addr_i), .wdata_i(cfg_wdata_i),
    .mode_o(cfg_mode), .div_o(cfg_div)
  );

  xfer_state_e      state_q;
  sel_mode_t        mode_q;
  logic [SEL_W-1:0] sel_q;
  logic [DIV_W-1:0] div_q;
  logic             sck_q, done_q;
  logic [DATA_W-1:0] rx_q, rx_sh;
  logic [NUM_SEL-1:0] cs_q;
  logic accept, tick, last_edge, run;

  assign accept = (state_q == ST_IDLE) && start_i;
  assign run    = (state_q == ST_RUN) || (state_q == ST_TAIL);

  spi_mcs_tick #(.DIV_W(DIV_W)) u_tick (
    .clk_i, .rst_ni, .run_i(run), .div_i(div_q), .tick_o(tick)
  );

  spi_mcs_shift #(.DATA_W(DATA_W)) u_shift (
    .clk_i, .rst_ni,
    .load_i(accept), .tx_i(tx_i),
    .edge_i(tick && state_q == ST_RUN), .nph_i(mode_q.nph),
    .miso_i(miso_i), .mosi_o(mosi_o), .rx_o(rx_sh), .last_o(last_edge)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      mode_q  <= '0;
      sel_q   <= '0;
      div_q   <= '0;
      sck_q   <= 1'b0;
      done_q  <= 1'b0;
      rx_q    <= '0;
    end else begin
      done_q <= 1'b0;
      unique case (state_q)
        ST_IDLE: if (start_i) begin
          sel_q   <= sel_i;
          mode_q  <= cfg_mode[sel_i];
          div_q   <= cfg_div;
          sck_q   <= cfg_mode[sel_i].pol;  // settle idle level before select
          state_q <= ST_ARM;
        end
        ST_ARM: state_q <= ST_RUN;
        ST_RUN: if (tick) begin
          sck_q <= ~sck_q;
          if (last_edge) state_q <= ST_TAIL;
        end
        ST_TAIL: if (tick) begin
          rx_q    <= rx_sh;
          done_q  <= 1'b1;
          state_q <= ST_IDLE;
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  for (genvar g = 0; g < NUM_SEL; g++) begin : g_cs
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                                     cs_q[g] <= 1'b1;
      else if (state_q == ST_ARM)                      cs_q[g] <= (sel_q != SEL_W'(g));
      else if (state_q == ST_TAIL && tick)             cs_q[g] <= 1'b1;
    end
  end

  assign ready_o = (state_q == ST_IDLE);
  assign done_o  = done_q;
  assign rx_o    = rx_q;
  assign sck_o   = sck_q;
  assign cs_no   = cs_q;

  assert_cs_onehot_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(~cs_no));
  assert_cs_idle_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ready_o |-> &cs_no);
  assert_cs_steady_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(&cs_no) |=> (&cs_no) || $stable(cs_no));
  assert_sck_settled_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(&cs_no) |-> $stable(sck_o) && sck_o == mode_q.pol);
  assert_sck_home_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> sck_o == mode_q.pol);
  assert_sck_paced_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !tick && !accept |=> $stable(sck_o));
  assert_done_pulse_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);
  assert_done_ready_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> ready_o);
  assert_rx_only_done_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(rx_o) |-> done_o);
  assert_mode_held_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ready_o && !accept |=> $stable(mode_q) || ready_o);
endmodule

// File: tb/spi_mcs_master_test.sv
module spi_mcs_master_test;
  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic       rst_n;
  logic       cfg_we = 0;
  logic [2:0] cfg_addr = '0;
  logic [7:0] cfg_wdata = '0;
  logic       start = 0;
  logic [1:0] sel = '0;
  logic [7:0] tx = '0;
  logic       ready, done, sck, mosi, miso;
  logic [7:0] rx;
  logic [3:0] cs_n;

  spi_mcs_master uut (
    .clk_i(clk), .rst_ni(rst_n),
    .cfg_we_i(cfg_we), .cfg_addr_i(cfg_addr), .cfg_wdata_i(cfg_wdata),
    .start_i(start), .sel_i(sel), .tx_i(tx),
    .ready_o(ready), .done_o(done), .rx_o(rx),
    .sck_o(sck), .mosi_o(mosi), .miso_i(miso), .cs_no(cs_n)
  );

  int n_chk = 0, n_bad = 0, n_done = 0, n_pushed = 0;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // bench model of stored settings
  logic bpol [4] = '{0, 0, 0, 0};
  logic bnph [4] = '{0, 0, 0, 0};
  int   bdiv = 0;

  typedef struct {
    int         s;
    logic [7:0] t;
    logic [7:0] r;
  } item_t;
  item_t q[$];

  // slave model: mode taken from the active select
  logic [7:0] s_tx [4];
  logic [7:0] s_rx = '0;
  logic       s_miso = 1'b0;
  logic [3:0] p_cs = 4'hF;
  logic       p_sck = 1'b0;
  int         s_oi = 0, s_act = 0, s_capt = 0;
  assign miso = s_miso;

  always @(cs_n or sck) begin
    if (p_cs == 4'hF && cs_n != 4'hF) begin
      for (int i = 0; i < 4; i++) if (!cs_n[i]) s_act = i;
      s_rx = '0; s_oi = 0; s_capt = 0;
      if (bnph[s_act]) begin s_miso = s_tx[s_act][7]; s_oi = 1; end
    end else if (cs_n != 4'hF && sck !== p_sck) begin
      if ((sck != bpol[s_act]) == bnph[s_act]) begin
        s_rx = {s_rx[6:0], mosi}; s_capt++;
      end else if (s_oi < 8) begin
        s_miso = s_tx[s_act][7 - s_oi]; s_oi++;
      end
    end
    p_cs = cs_n; p_sck = sck;
  end

  // monitor
  int cyc = 0, last_evt = 0, n_edges = 0;
  logic [3:0] m_cs = 4'hF;
  logic m_sck = 1'b0, m_done = 1'b0;
  always @(negedge clk) begin
    cyc++;
    if (rst_n) begin
      if (m_cs == 4'hF && cs_n != 4'hF) begin
        int s;
        s = (q.size() > 0) ? q[0].s : -1;
        chk(s >= 0 && cs_n == ~(4'b1 << s), "R4 select low", cs_n, ~(4'b1 << s));
        if (s >= 0) begin
          chk(sck == bpol[s], "R3 sck idle at select", sck, bpol[s]);
          if (bnph[s]) chk(mosi == q[0].t[7], "R5 first bit before edge", mosi, q[0].t[7]);
        end
        last_evt = cyc; n_edges = 0;
      end else if (cs_n != 4'hF) begin
        chk(cs_n == m_cs, "R4 select steady", cs_n, m_cs);
        chk(!ready, "R8 busy", ready, 0);
        if (sck != m_sck) begin
          chk(cyc - last_evt == bdiv + 1, "R7 half period", cyc - last_evt, bdiv + 1);
          last_evt = cyc; n_edges++;
        end
      end
      if (m_done && done) chk(0, "R8 done width", 2, 1);
      if (done) begin
        item_t it;
        n_done++;
        if (q.size() == 0) chk(0, "R8 extra done", n_done, n_pushed);
        else begin
          it = q.pop_front();
          chk(rx == it.r, "R6 received byte", rx, it.r);
          chk(s_rx == it.t, "R5 byte seen by slave", s_rx, it.t);
          chk(n_edges == 16, "R5 edge count", n_edges, 16);
          chk(s_capt == 8, "R5 slave captures", s_capt, 8);
          chk(ready && cs_n == 4'hF, "R8 ready at done", {ready, cs_n}, 5'h1F);
          chk(sck == bpol[it.s], "R3 sck home", sck, bpol[it.s]);
        end
      end
    end
    m_cs = cs_n; m_sck = sck; m_done = done;
  end

  task automatic wcfg(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk);
    while (!ready) @(negedge clk);
    cfg_we = 1; cfg_addr = a; cfg_wdata = d;
    @(negedge clk);
    cfg_we = 0;
    if (a < 4) begin bpol[a] = d[0]; bnph[a] = d[1]; end
    else if (a == 4) bdiv = d;
  endtask

  task automatic xfer(input int s, input logic [7:0] t, input logic [7:0] r, input bit poke);
    item_t it;
    @(negedge clk);
    while (!ready) @(negedge clk);
    s_tx[s] = r;
    it.s = s; it.t = t; it.r = r;
    q.push_back(it); n_pushed++;
    start = 1; sel = 2'(s); tx = t;
    @(negedge clk);
    start = 0;
    if (poke) begin
      repeat (3) @(negedge clk);
      start = 1; sel = 2'(s + 1); tx = ~t;  // R8: ignored while busy
      @(negedge clk);
      start = 0;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog expired");
    $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end

  initial begin
    for (int i = 0; i < 4; i++) s_tx[i] = '0;
    rst_n = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1 reset state
    chk(cs_n == 4'hF, "R1 selects", cs_n, 4'hF);
    chk(sck == 0, "R1 sck", sck, 0);
    chk(ready == 1 && done == 0, "R1 ready/done", {ready, done}, 2'b10);
    chk(rx == 0, "R1 rx", rx, 0);

    // R2 default entries: mode nph=0 pol=0, divider 0
    xfer(2, 8'hC3, 8'h5A, 0);

    // R2/R9 one mode per select: 0=(pol0,nph1) 1=(pol0,nph0) 2=(pol1,nph1) 3=(pol1,nph0)
    wcfg(3'd0, 8'h02);
    wcfg(3'd1, 8'h00);
    wcfg(3'd2, 8'h03);
    wcfg(3'd3, 8'h01);
    // R9 back-to-back transfers switching selects, divider 0
    xfer(0, 8'hA5, 8'h3C, 0);
    xfer(1, 8'h81, 8'h7E, 0);
    xfer(2, 8'hFF, 8'h00, 0);
    xfer(3, 8'h00, 8'hFF, 0);
    xfer(2, 8'h69, 8'h96, 0);
    xfer(0, 8'h01, 8'h80, 0);
    xfer(3, 8'h5A, 8'hA5, 0);
    xfer(1, 8'h18, 8'hE7, 0);

    // R7 slower clock
    wcfg(3'd4, 8'd3);
    for (int s = 0; s < 4; s++) xfer(s, 8'(8'h35 + s * 17), 8'(8'hC9 ^ s * 33), 0);

    // R2 writes to 5..7 ignored: modes and divider stay
    wcfg(3'd5, 8'hFF);
    wcfg(3'd6, 8'hFF);
    wcfg(3'd7, 8'hFF);
    xfer(1, 8'h92, 8'h4D, 0);
    xfer(2, 8'h6C, 8'hB1, 0);

    // R8 start while busy is ignored
    wcfg(3'd4, 8'd1);
    xfer(3, 8'hE1, 8'h1E, 1);
    xfer(0, 8'h47, 8'hB8, 1);

    while (q.size() != 0) @(negedge clk);
    repeat (20) @(negedge clk);
    chk(n_done == n_pushed, "R8 one done per start", n_done, n_pushed);
    chk(cs_n == 4'hF && ready, "R4 idle after run", cs_n, 4'hF);
    $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end
endmodule